// File: doc/BRIEF.md
# Packed Tile Pixel Fetch Unit

This block fetches one colour index from a tile stored in packed form. Each tile is a 16x16 grid of 3-bit colour indices. Tile memory uses 16-bit words, and each word holds five pixels plus one padding bit that is never read. Every tile therefore takes 52 words, and tile number `t` starts at word `52*t`. A request carries a tile number, a column and a row inside the tile, and two mirror flags. The block applies the mirrors to the coordinates first. It then forms the pixel number `p = 16*row + column` and drives the word address `52*t + floor(p/5)`. In the following cycle it takes the returned word apart and outputs the wanted 3-bit field.

The background renderer and the sprite renderer both use the same unit. The tile memory is read asynchronously: the word for the driven address must be present on the read-data input during the cycle that follows the request. A new request may be issued on every cycle. Results come out in request order, two clock edges after the request is sampled.

Top module: `tile_texel_fetch`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next state has `mem_rd_en`=0, `mem_addr`=0, `pix_valid`=0 and `pix_color`=0, whatever the request inputs are.
- R2: A request sampled with `req_valid`=1 at an edge drives `mem_addr` = 52*`req_tile` + floor(p/5) with `mem_rd_en`=1 after that edge, where p = 16*y' + x' and (x', y') are the coordinates after mirroring.
- R3: With `req_hflip`=1 the column used is x' = 15 - `req_x`; otherwise x' = `req_x`.
- R4: With `req_vflip`=1 the row used is y' = 15 - `req_y`; otherwise y' = `req_y`.
- R5: One edge after `mem_rd_en` is high, `pix_valid`=1 and `pix_color` holds bits [3s+2:3s] of the `mem_rdata` word present in the read cycle, where s = p mod 5. Slot 0 is bits 2..0 and slot 4 is bits 14..12.
- R6: Bit 15 of a word never affects `pix_color`. For pixel 255 (slot 0 of a tile's last word), bits 15..3 have no effect.
- R7: A cycle with `req_valid`=0 leaves `mem_rd_en`=0 and `mem_addr` unchanged after the next edge, and `pix_valid`=0 one edge after that.
- R8: Requests on consecutive cycles each produce one result, one per cycle, in issue order.
- R9: Every driven address is below 1024*52 = 53248. Tile 1023, pixel 255 gives 53247.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A fetch request is present this cycle |
| req_tile | input | 10 | Tile number |
| req_x | input | 4 | Column inside the tile, before mirroring |
| req_y | input | 4 | Row inside the tile, before mirroring |
| req_hflip | input | 1 | Mirror the column |
| req_vflip | input | 1 | Mirror the row |
| mem_rd_en | output | 1 | Read address is valid |
| mem_addr | output | 16 | Tile memory word address |
| mem_rdata | input | 16 | Word returned by the asynchronous tile memory |
| pix_valid | output | 1 | `pix_color` is valid |
| pix_color | output | 3 | Extracted colour index |

## Verification
The bench goes after the edges of the divide-by-five. Pixels 0, 4, 5 and 255 sit on slot and word boundaries. A divider that is off by one there puts the address one word too far or the field three bits too far. It tests every mirror combination at the tile corners, because a mirror applied after the pixel number is formed, or applied to the wrong axis, sends a corner pixel to a different word. It corrupts the padding bit, and the unused upper bits of the last word, with a bench memory mask. A field selector that reads the wrong bits then shows a different colour. Back-to-back and gapped streams expose a pipeline that drops, repeats or fails to hold a result.

// File: rtl/ttf_pkg.sv
// Shared definitions for the packed tile pixel fetch unit.
// Assumes every size is a positive integer known at elaboration.
package ttf_pkg;

    // Integer ceiling division, used to size the per-tile word stride.
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    // Mirror selection carried alongside a coordinate pair.
    typedef struct packed {
        logic horiz;
        logic vert;
    } mirror_t;

endpackage

// File: rtl/ttf_mirror.sv
// Mirrors an in-tile coordinate pair on either axis.
// Assumes the tile side is a power of two, so that side-1-c equals ~c.
module ttf_mirror
    import ttf_pkg::*;
#(
    parameter int COORD_W = 4
) (
    input  logic [COORD_W-1:0] col_in,
    input  logic [COORD_W-1:0] row_in,
    input  mirror_t            mirror,
    output logic [COORD_W-1:0] col_out,
    output logic [COORD_W-1:0] row_out
);

    // Select the reflected or the straight coordinate for each axis.
    always_comb begin
        col_out = mirror.horiz ? ~col_in : col_in;
        row_out = mirror.vert  ? ~row_in : row_in;
    end

endmodule

// File: rtl/ttf_word_locate.sv
// Turns tile number and mirrored coordinates into a word address and the
// pixel slot inside that word. It divides by the pixels-per-word constant
// with an unrolled restoring divider (one stage per pixel-number bit).
// Assumes the tile grid side is 2**COORD_W and the result fits ADDR_W.
module ttf_word_locate
    import ttf_pkg::*;
#(
    parameter int COORD_W      = 4,
    parameter int TILE_W       = 10,
    parameter int ADDR_W       = 16,
    parameter int PIX_PER_WORD = 5,
    localparam int PIX_W       = 2 * COORD_W,
    localparam int SLOT_W      = $clog2(PIX_PER_WORD),
    localparam int STRIDE      = ceil_div(2 ** PIX_W, PIX_PER_WORD)
) (
    input  logic [TILE_W-1:0]  tile,
    input  logic [COORD_W-1:0] col,
    input  logic [COORD_W-1:0] row,
    output logic [ADDR_W-1:0]  word_addr,
    output logic [SLOT_W-1:0]  slot
);

    localparam logic [SLOT_W:0] DIVISOR = (SLOT_W + 1)'(PIX_PER_WORD);

    logic [PIX_W-1:0] pix_num;
    logic [PIX_W-1:0] quo;

    // Reading-order pixel number: row-major inside the tile.
    assign pix_num = {row, col};

    // One restoring-division stage per pixel-number bit, MSB first.
    for (genvar i = 0; i < PIX_W; i++) begin : g_div
        logic [SLOT_W-1:0] r_in;
        logic [SLOT_W:0]   trial;
        logic [SLOT_W-1:0] r_out;
        if (i == PIX_W - 1) begin : g_first
            assign r_in = '0;
        end else begin : g_next
            assign r_in = g_div[i+1].r_out;
        end
        assign trial  = {r_in, pix_num[i]};
        assign quo[i] = (trial >= DIVISOR);
        assign r_out  = quo[i] ? SLOT_W'(trial - DIVISOR) : trial[SLOT_W-1:0];
    end

    assign slot = g_div[0].r_out;

    // Tile base at a fixed stride plus the word offset inside the tile.
    assign word_addr = ADDR_W'(tile) * ADDR_W'(STRIDE) + ADDR_W'(quo);

    // Divider self-consistency: quotient and remainder rebuild the pixel.
    always_comb begin
        AST_DIV_EXACT: assert ((32'(quo) * PIX_PER_WORD + 32'(slot)) == 32'(pix_num)); // R2
        AST_SLOT_RANGE: assert (32'(slot) < PIX_PER_WORD); // R5
    end

endmodule

// File: rtl/ttf_field_pick.sv
// Selects one BPP-wide field of a memory word by slot number.
// Slot k occupies bits [k*BPP+BPP-1 : k*BPP]; bits above the last slot
// (padding) are never routed to the output.
module ttf_field_pick #(
    parameter int DATA_W       = 16,
    parameter int BPP          = 3,
    parameter int PIX_PER_WORD = 5,
    localparam int SLOT_W      = $clog2(PIX_PER_WORD)
) (
    input  logic [DATA_W-1:0] word,
    input  logic [SLOT_W-1:0] slot,
    output logic [BPP-1:0]    field
);

    logic [BPP-1:0] fields [PIX_PER_WORD];

    // Split the word into its packed pixel fields.
    for (genvar k = 0; k < PIX_PER_WORD; k++) begin : g_field
        assign fields[k] = word[k*BPP +: BPP];
    end

    // Route the field addressed by the slot number.
    always_comb begin
        field = '0;
        for (int k = 0; k < PIX_PER_WORD; k++) begin
            if (32'(slot) == k) field = fields[k];
        end
    end

endmodule

// File: rtl/tile_texel_fetch.sv
// Two-stage packed tile pixel fetch. Stage one registers the word address
// derived from a request; stage two captures the field from the word an
// asynchronous tile memory returns for that address.
// Assumes the memory answers within the cycle the address is held.
module tile_texel_fetch
    import ttf_pkg::*;
#(
    parameter int COORD_W      = 4,
    parameter int TILE_W       = 10,
    parameter int ADDR_W       = 16,
    parameter int DATA_W       = 16,
    parameter int BPP          = 3,
    parameter int PIX_PER_WORD = 5,
    localparam int SLOT_W      = $clog2(PIX_PER_WORD),
    localparam int STRIDE      = ceil_div(2 ** (2 * COORD_W), PIX_PER_WORD),
    localparam int ADDR_LIMIT  = (2 ** TILE_W) * STRIDE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [TILE_W-1:0]  req_tile,
    input  logic [COORD_W-1:0] req_x,
    input  logic [COORD_W-1:0] req_y,
    input  logic               req_hflip,
    input  logic               req_vflip,
    output logic               mem_rd_en,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               pix_valid,
    output logic [BPP-1:0]     pix_color
);

    mirror_t             mirror;
    logic [COORD_W-1:0]  col_m;
    logic [COORD_W-1:0]  row_m;
    logic [ADDR_W-1:0]   addr_d;
    logic [SLOT_W-1:0]   slot_d;
    logic [SLOT_W-1:0]   slot_q;
    logic [BPP-1:0]      field_d;

    assign mirror = '{horiz: req_hflip, vert: req_vflip};

    ttf_mirror #(.COORD_W(COORD_W)) u_mirror (
        .col_in  (req_x),
        .row_in  (req_y),
        .mirror  (mirror),
        .col_out (col_m),
        .row_out (row_m)
    );

    ttf_word_locate #(
        .COORD_W      (COORD_W),
        .TILE_W       (TILE_W),
        .ADDR_W       (ADDR_W),
        .PIX_PER_WORD (PIX_PER_WORD)
    ) u_locate (
        .tile      (req_tile),
        .col       (col_m),
        .row       (row_m),
        .word_addr (addr_d),
        .slot      (slot_d)
    );

    // Stage one: present the address; hold it while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_rd_en <= 1'b0;
            mem_addr  <= '0;
            slot_q    <= '0;
        end else begin
            mem_rd_en <= req_valid;
            if (req_valid) begin
                mem_addr <= addr_d;
                slot_q   <= slot_d;
            end
        end
    end

    ttf_field_pick #(
        .DATA_W       (DATA_W),
        .BPP          (BPP),
        .PIX_PER_WORD (PIX_PER_WORD)
    ) u_pick (
        .word  (mem_rdata),
        .slot  (slot_q),
        .field (field_d)
    );

    // Stage two: capture the selected pixel from the returned word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_valid <= 1'b0;
            pix_color <= '0;
        end else begin
            pix_valid <= mem_rd_en;
            if (mem_rd_en) pix_color <= field_d;
        end
    end

    AST_RD_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> mem_rd_en); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!mem_rd_en && $stable(mem_addr))); // R7
    AST_PIX_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> pix_valid); // R5
    AST_NO_STRAY_PIX: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_en |=> !pix_valid); // R7
    AST_ADDR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (32'(mem_addr) < ADDR_LIMIT)); // R9
    AST_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && $past(req_valid)) |=> (mem_rd_en && pix_valid)); // R8

endmodule

// File: tb/tile_texel_fetch_test.sv
module tile_texel_fetch_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [9:0]  req_tile = '0;
    logic [3:0]  req_x = '0;
    logic [3:0]  req_y = '0;
    logic        req_hflip = 1'b0;
    logic        req_vflip = 1'b0;
    logic        mem_rd_en;
    logic [15:0] mem_addr;
    logic [15:0] mem_rdata;
    logic        pix_valid;
    logic [2:0]  pix_color;

    logic [15:0] mask = '0;
    int checks = 0;
    int fails  = 0;
    bit chk_en = 1'b0;
    bit done   = 1'b0;

    string cur_tag = "R2";

    always #2 clk = ~clk;

    tile_texel_fetch uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tile(req_tile),
        .req_x(req_x), .req_y(req_y), .req_hflip(req_hflip), .req_vflip(req_vflip),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .pix_valid(pix_valid), .pix_color(pix_color)
    );

    // Bench memory content: a fixed scramble of the address.
    function automatic logic [15:0] mem_word(input logic [15:0] a);
        logic [31:0] m;
        m = 32'(a) * 32'h9E37;
        return m[15:0] ^ {a[7:0], a[15:8]} ^ 16'h5A3C;
    endfunction

    assign mem_rdata = mem_word(mem_addr) ^ mask;

    function automatic int exp_pix(input int x, input int y, input bit h, input bit v);
        int xx, yy;
        xx = h ? 15 - x : x;   // R3
        yy = v ? 15 - y : y;   // R4
        return 16 * yy + xx;
    endfunction

    function automatic int exp_addr(input int t, input int p);
        return 52 * t + p / 5;
    endfunction

    function automatic int exp_color(input int a, input int p);
        logic [15:0] w;
        w = mem_word(16'(a));
        return int'((w >> (3 * (p % 5))) & 16'h7);
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Bench pipeline of expectations.
    bit    s1_v = 0, s2_v = 0;
    int    s1_a = 0, s2_a = 0, s1_c = 0, s2_c = 0;
    string s1_t = "", s2_t = "";
    int    last_addr = 0;

    always @(negedge clk) begin
        if (chk_en) begin
            if (s1_v) begin
                check(s1_t, "mem_rd_en", int'(mem_rd_en), 1);
                check(s1_t, "mem_addr", int'(mem_addr), s1_a);
                last_addr = s1_a;
            end else begin
                check("R7", "idle mem_rd_en", int'(mem_rd_en), 0);
                check("R7", "idle mem_addr hold", int'(mem_addr), last_addr);
            end
            if (s2_v) begin
                check(s2_t, "pix_valid", int'(pix_valid), 1);
                check({s2_t, "/R5"}, "pix_color", int'(pix_color), s2_c);
            end else begin
                check("R7", "idle pix_valid", int'(pix_valid), 0);
            end
            s2_v = s1_v; s2_a = s1_a; s2_c = s1_c; s2_t = s1_t;
            s1_v = req_valid;
            if (req_valid) begin
                int p;
                p = exp_pix(int'(req_x), int'(req_y), req_hflip, req_vflip);
                s1_a = exp_addr(int'(req_tile), p);
                s1_c = exp_color(s1_a, p);
                s1_t = cur_tag;
            end
        end
    end

    task automatic issue(input int t, input int x, input int y, input bit h, input bit v,
                         input string tag);
        @(posedge clk); #1;
        req_valid = 1'b1; req_tile = 10'(t); req_x = 4'(x); req_y = 4'(y);
        req_hflip = h; req_vflip = v; cur_tag = tag;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            req_valid = 1'b0;
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset dominates a pending request.
        req_valid = 1'b1; req_tile = 10'd7; req_x = 4'd3; req_y = 4'd9;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "reset mem_rd_en", int'(mem_rd_en), 0);
        check("R1", "reset mem_addr", int'(mem_addr), 0);
        check("R1", "reset pix_valid", int'(pix_valid), 0);
        check("R1", "reset pix_color", int'(pix_color), 0);
        @(posedge clk); #1;
        req_valid = 1'b0; rst_n = 1'b1; chk_en = 1'b1;
        idle(2);

        // Divider boundaries: pixels 0, 4, 5, 9, 10, 254, 255.
        issue(0, 0, 0, 0, 0, "R2");
        issue(0, 4, 0, 0, 0, "R2");
        issue(0, 5, 0, 0, 0, "R2");
        issue(3, 9, 0, 0, 0, "R2");
        issue(3, 10, 0, 0, 0, "R2");
        issue(12, 14, 15, 0, 0, "R2");
        issue(1023, 15, 15, 0, 0, "R9");
        idle(3);

        // Mirror corners for every flip combination.
        for (int m = 0; m < 4; m++) begin
            issue(100, 0, 0, m[0], m[1], m[0] ? "R3" : "R4");
            issue(100, 15, 0, m[0], m[1], "R3");
            issue(100, 0, 15, m[0], m[1], "R4");
            issue(100, 15, 15, m[0], m[1], "R4");
            issue(101, 3, 7, m[0], m[1], "R3");
        end
        idle(3);

        // Gapped stream: idle cycles between requests.
        for (int i = 0; i < 30; i++) begin
            issue(int'($urandom_range(1023)), int'($urandom_range(15)),
                  int'($urandom_range(15)), 1'($urandom), 1'($urandom), "R7");
            idle(int'($urandom_range(3)));
        end
        idle(3);

        // Back-to-back random stream.
        for (int i = 0; i < 400; i++)
            issue(int'($urandom_range(1023)), int'($urandom_range(15)),
                  int'($urandom_range(15)), 1'($urandom), 1'($urandom), "R8");
        idle(3);

        // R6: padding bit corrupted on every word read.
        mask = 16'h8000;
        for (int i = 0; i < 40; i++)
            issue(int'($urandom_range(1023)), int'($urandom_range(15)),
                  int'($urandom_range(15)), 1'($urandom), 1'($urandom), "R6");
        idle(3);

        // R6: unused upper bits of a tile's last word corrupted.
        mask = 16'hFFF8;
        issue(0, 15, 15, 0, 0, "R6");
        issue(1023, 15, 15, 0, 0, "R6");
        issue(512, 0, 0, 1, 1, "R6");
        for (int i = 0; i < 10; i++)
            issue(int'($urandom_range(1023)), 15, 15, 0, 0, "R6");
        idle(3);
        mask = '0;
        idle(2);

        done = 1'b1;
        finish_run();
    end

endmodule